// File: doc/BRIEF.md
# D4 Superframe Framing Bit Engine

This block produces and checks the framing bit stream of a T1 link in the twelve-frame superframe format, and handles robbed-bit signaling. Frames are 193 bits long: a single framing bit (the S-bit) followed by 24 eight-bit channel words, each sent most significant bit first. Odd-numbered frames carry terminal-framing bits that alternate 1,0,1,0 across the superframe. Even-numbered frames carry superframe-alignment bits in the fixed order 0,0,1,1,1,0, and that order is what marks the superframe boundary.

The transmit side runs one line bit per clock. In the S-bit cycle it samples 24 parallel channel words plus the per-channel signaling bits and enables. It then shifts the frame out serially. In frame 6 an enabled channel has its least significant bit replaced by its A signaling bit, and in frame 12 by its B signaling bit. The receive side takes a serial stream that is already frame-aligned. A sync pulse marks the S-bit of frame 1. The receive side checks every S-bit against the expected value, reports terminal-framing and superframe-alignment mismatches on separate strobes, gives a superframe-start strobe, and captures each channel's A and B bits from the least significant bit positions of frames 6 and 12.

Top module: `d4_framer`

## Requirements
- R1: While rst_ni is low, tx_bit_o is 1, tx_load_o is 1, tx_frame_o is 1, all three receive strobes are 0 and rx_sig_a_o and rx_sig_b_o are all zero.
- R2: The transmit S-bit of frame n (tx_frame_o = n, 1..12) is 1,0,0,0,1,1,0,1,1,1,0,0 for n = 1..12. Odd frames carry 1,0,1,0,1,0 and even frames carry 0,0,1,1,1,0. tx_frame_o advances by one at each frame start and wraps from 12 to 1.
- R3: A transmit frame lasts 193 cycles. tx_load_o is high only in the S-bit cycle. tx_data_i is sampled at the clock edge that ends that cycle. The next 192 cycles send channel c (c = 0 first) from tx_data_i[8c+7:8c], MSB first.
- R4: In frame 6, a channel c with tx_rob_en_i[c] = 1 sends tx_sig_a_i[c] (sampled with the data) in place of its LSB.
- R5: In frame 12, a channel c with tx_rob_en_i[c] = 1 sends tx_sig_b_i[c] in place of its LSB.
- R6: When tx_rob_en_i[c] = 0, or in any frame other than 6 and 12, channel c's LSB goes out unchanged and the signaling inputs have no effect.
- R7: rx_ft_err_o pulses for one cycle, one cycle after an odd-frame receive S-bit that differs from the R2 value.
- R8: rx_fs_err_o pulses for one cycle, one cycle after an even-frame receive S-bit that differs from the R2 value.
- R9: rx_sf_start_o pulses one cycle after the receive S-bit of frame 1, whether or not that bit is in error.
- R10: When rx_sf_sync_i is high, the bit on rx_bit_i in that cycle is taken as the frame-1 S-bit, and receive counting continues from there. Without it, the receive side free-runs from reset in 193-bit frames.
- R11: One cycle after the LSB of channel c is received in frame 6, rx_sig_a_o[c] takes that bit. In frame 12 it is rx_sig_b_o[c] instead. The outputs hold their value at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Line bit clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_data_i | input | 192 | Channel words, channel c in bits 8c+7:8c |
| tx_sig_a_i | input | 24 | A signaling bit per channel |
| tx_sig_b_i | input | 24 | B signaling bit per channel |
| tx_rob_en_i | input | 24 | Per-channel robbed-bit enable |
| tx_bit_o | output | 1 | Serial transmit bit |
| tx_load_o | output | 1 | High in the S-bit cycle; inputs sampled at its end |
| tx_frame_o | output | 4 | Frame number 1..12 being sent |
| rx_bit_i | input | 1 | Serial receive bit |
| rx_sf_sync_i | input | 1 | Marks the current receive bit as frame-1 S-bit |
| rx_ft_err_o | output | 1 | Terminal-framing bit mismatch strobe |
| rx_fs_err_o | output | 1 | Superframe-alignment bit mismatch strobe |
| rx_sf_start_o | output | 1 | Superframe start strobe |
| rx_sig_a_o | output | 24 | Captured A signaling bits |
| rx_sig_b_o | output | 24 | Captured B signaling bits |

## Verification
The superframe-start strobe and the terminal-framing error strobe can fire in the same cycle, because frame 1 carries a terminal-framing bit. The bench corrupts frame-1 S-bits on purpose, both at a fixed superframe and at random, and expects both strobes together, with the superframe-alignment strobe staying low. A realignment pulse can also arrive in the same cycle as a bit the free-running count would have judged differently. The bench shifts its receive stream by 57 bits and then pulses sync, so mismatches before the pulse, the realigned frame-1 strobe and the later error-free frames are all judged by the bench's own frame count.

// File: rtl/d4_pkg.sv
package d4_pkg;
  localparam int unsigned SF_FRAMES = 12;
  localparam int unsigned FRAME_W   = 4;

  localparam logic [FRAME_W-1:0] FRAME_FIRST = 4'd0;
  localparam logic [FRAME_W-1:0] FRAME_LAST  = 4'd11;
  localparam logic [FRAME_W-1:0] FRAME_SIG_A = 4'd5;
  localparam logic [FRAME_W-1:0] FRAME_SIG_B = 4'd11;

  // bit k = k-th alignment bit of the superframe
  localparam logic [5:0] FS_SEQ = 6'b011100;

  // fidx is 0-based; even index = odd frame number = terminal-framing bit
  function automatic logic exp_sbit(input logic [FRAME_W-1:0] fidx);
    logic [FRAME_W-2:0] k;
    k = fidx[FRAME_W-1:1];
    if (!fidx[0]) return ~k[0];
    return FS_SEQ[k];
  endfunction
endpackage

// File: rtl/d4_frame_counter.sv
module d4_frame_counter
  import d4_pkg::*;
#(
  parameter int unsigned FRAME_BITS = 193,
  localparam int unsigned BIT_W = $clog2(FRAME_BITS)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               restart_i,
  output logic [BIT_W-1:0]   bit_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  logic [BIT_W-1:0]   bit_q;
  logic [FRAME_W-1:0] frame_q;

  assign bit_o   = restart_i ? '0 : bit_q;
  assign frame_o = restart_i ? FRAME_FIRST : frame_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= '0;
      frame_q <= FRAME_FIRST;
    end else if (bit_o == LAST_BIT) begin
      bit_q   <= '0;
      frame_q <= (frame_o == FRAME_LAST) ? FRAME_FIRST : frame_o + 1'b1;
    end else begin
      bit_q   <= bit_o + 1'b1;
      frame_q <= frame_o;
    end
  end
endmodule

// File: rtl/d4_rob_insert.sv
module d4_rob_insert
  import d4_pkg::*;
#(
  parameter int unsigned CH_BITS = 8
) (
  input  logic [CH_BITS-1:0] word_i,
  input  logic               sig_a_i,
  input  logic               sig_b_i,
  input  logic               en_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CH_BITS-1:0] word_o
);
  logic lsb;

  always_comb begin
    lsb = word_i[0];
    if (en_i && frame_i == FRAME_SIG_A) lsb = sig_a_i;
    else if (en_i && frame_i == FRAME_SIG_B) lsb = sig_b_i;
  end

  assign word_o = {word_i[CH_BITS-1:1], lsb};
endmodule

// File: rtl/d4_tx_path.sv
module d4_tx_path
  import d4_pkg::*;
#(
  parameter int unsigned CHANNELS = 24,
  parameter int unsigned CH_BITS  = 8,
  localparam int unsigned PAY_BITS = CHANNELS * CH_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PAY_BITS-1:0] data_i,
  input  logic [CHANNELS-1:0] sig_a_i,
  input  logic [CHANNELS-1:0] sig_b_i,
  input  logic [CHANNELS-1:0] rob_en_i,
  output logic                bit_o,
  output logic                load_o,
  output logic [FRAME_W-1:0]  frame_o
);
  localparam int unsigned FRAME_BITS = PAY_BITS + 1;
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic [BIT_W-1:0]    pos;
  logic [FRAME_W-1:0]  fidx;
  logic [PAY_BITS-1:0] pay_ld;
  logic [PAY_BITS-1:0] pay_q;

  d4_frame_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(1'b0),
    .bit_o    (pos),
    .frame_o  (fidx)
  );

  assign load_o = (pos == '0);

  // channel 0 lands in the top byte so it leaves first
  for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
    d4_rob_insert #(.CH_BITS(CH_BITS)) u_rob (
      .word_i (data_i[c*CH_BITS +: CH_BITS]),
      .sig_a_i(sig_a_i[c]),
      .sig_b_i(sig_b_i[c]),
      .en_i   (rob_en_i[c]),
      .frame_i(fidx),
      .word_o (pay_ld[PAY_BITS-1-c*CH_BITS -: CH_BITS])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pay_q <= '0;
    else if (load_o) pay_q <= pay_ld;
    else             pay_q <= {pay_q[PAY_BITS-2:0], 1'b0};
  end

  assign bit_o   = load_o ? exp_sbit(fidx) : pay_q[PAY_BITS-1];
  assign frame_o = fidx + 1'b1;
endmodule

// File: rtl/d4_rx_path.sv
module d4_rx_path
  import d4_pkg::*;
#(
  parameter int unsigned CHANNELS = 24,
  parameter int unsigned CH_BITS  = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_i,
  input  logic                sync_i,
  output logic                ft_err_o,
  output logic                fs_err_o,
  output logic                sf_start_o,
  output logic [CHANNELS-1:0] sig_a_o,
  output logic [CHANNELS-1:0] sig_b_o
);
  localparam int unsigned FRAME_BITS = CHANNELS * CH_BITS + 1;
  localparam int unsigned BIT_W = $clog2(FRAME_BITS);

  logic [BIT_W-1:0]   pos;
  logic [FRAME_W-1:0] fidx;
  logic               s_cyc;
  logic               s_bad;

  d4_frame_counter #(.FRAME_BITS(FRAME_BITS)) u_cnt (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(sync_i),
    .bit_o    (pos),
    .frame_o  (fidx)
  );

  assign s_cyc = (pos == '0);
  assign s_bad = s_cyc && (bit_i != exp_sbit(fidx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ft_err_o   <= 1'b0;
      fs_err_o   <= 1'b0;
      sf_start_o <= 1'b0;
    end else begin
      ft_err_o   <= s_bad && !fidx[0];
      fs_err_o   <= s_bad &&  fidx[0];
      sf_start_o <= s_cyc && (fidx == FRAME_FIRST);
    end
  end

  for (genvar c = 0; c < CHANNELS; c++) begin : g_sig
    localparam logic [BIT_W-1:0] LSB_POS = BIT_W'((c + 1) * CH_BITS);
    logic a_q, b_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        a_q <= 1'b0;
        b_q <= 1'b0;
      end else if (pos == LSB_POS) begin
        if (fidx == FRAME_SIG_A) a_q <= bit_i;
        if (fidx == FRAME_SIG_B) b_q <= bit_i;
      end
    end
    assign sig_a_o[c] = a_q;
    assign sig_b_o[c] = b_q;
  end
endmodule

// File: rtl/d4_framer.sv
module d4_framer #(
  parameter int unsigned CHANNELS = 24,
  parameter int unsigned CH_BITS  = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [CHANNELS*CH_BITS-1:0]  tx_data_i,
  input  logic [CHANNELS-1:0]          tx_sig_a_i,
  input  logic [CHANNELS-1:0]          tx_sig_b_i,
  input  logic [CHANNELS-1:0]          tx_rob_en_i,
  output logic                         tx_bit_o,
  output logic                         tx_load_o,
  output logic [3:0]                   tx_frame_o,
  input  logic                         rx_bit_i,
  input  logic                         rx_sf_sync_i,
  output logic                         rx_ft_err_o,
  output logic                         rx_fs_err_o,
  output logic                         rx_sf_start_o,
  output logic [CHANNELS-1:0]          rx_sig_a_o,
  output logic [CHANNELS-1:0]          rx_sig_b_o
);
  d4_tx_path #(.CHANNELS(CHANNELS), .CH_BITS(CH_BITS)) u_tx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .data_i  (tx_data_i),
    .sig_a_i (tx_sig_a_i),
    .sig_b_i (tx_sig_b_i),
    .rob_en_i(tx_rob_en_i),
    .bit_o   (tx_bit_o),
    .load_o  (tx_load_o),
    .frame_o (tx_frame_o)
  );

  d4_rx_path #(.CHANNELS(CHANNELS), .CH_BITS(CH_BITS)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .bit_i     (rx_bit_i),
    .sync_i    (rx_sf_sync_i),
    .ft_err_o  (rx_ft_err_o),
    .fs_err_o  (rx_fs_err_o),
    .sf_start_o(rx_sf_start_o),
    .sig_a_o   (rx_sig_a_o),
    .sig_b_o   (rx_sig_b_o)
  );
endmodule

// File: rtl/d4_framer_checker.sv
module d4_framer_checker (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_load_o,
  input logic [3:0] tx_frame_o,
  input logic       rx_ft_err_o,
  input logic       rx_fs_err_o,
  input logic       rx_sf_start_o
);
  AST_TX_FRAME_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_frame_o >= 4'd1 && tx_frame_o <= 4'd12); // R2

  AST_TX_FRAME_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_load_o && tx_frame_o != 4'd1) |-> tx_frame_o == $past(tx_frame_o) + 4'd1); // R2

  AST_TX_FRAME_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_load_o |-> $stable(tx_frame_o)); // R3

  AST_TX_LOAD_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |=> !tx_load_o); // R3

  AST_RX_ERR_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_ft_err_o && rx_fs_err_o)); // R8

  AST_RX_SF_NO_FS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_sf_start_o |-> !rx_fs_err_o); // R9
endmodule

bind d4_framer d4_framer_checker u_d4_chk (.*);

// File: tb/d4_framer_bench.sv
module d4_framer_bench;
  localparam int CH = 24;
  localparam int CB = 8;
  localparam int FB = CH * CB + 1;
  localparam int SF = 12 * FB;
  localparam int RUN = 6 * SF;
  localparam int JUMP_T = 3 * SF + 400;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic            rst_ni;
  logic [CH*CB-1:0] tx_data;
  logic [CH-1:0]   tx_a, tx_b, tx_en;
  logic            tx_bit, tx_load;
  logic [3:0]      tx_frame;
  logic            rx_bit, rx_sync;
  logic            rx_ft, rx_fs, rx_sf;
  logic [CH-1:0]   rx_a, rx_b;

  d4_framer u_d4_framer (
    .clk_i(clk), .rst_ni(rst_ni),
    .tx_data_i(tx_data), .tx_sig_a_i(tx_a), .tx_sig_b_i(tx_b), .tx_rob_en_i(tx_en),
    .tx_bit_o(tx_bit), .tx_load_o(tx_load), .tx_frame_o(tx_frame),
    .rx_bit_i(rx_bit), .rx_sf_sync_i(rx_sync),
    .rx_ft_err_o(rx_ft), .rx_fs_err_o(rx_fs), .rx_sf_start_o(rx_sf),
    .rx_sig_a_o(rx_a), .rx_sig_b_o(rx_b)
  );

  int checks = 0;
  int errs = 0;
  bit done = 0;

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic sref(int n);
    case (n)
      1: return 1'b1;  2: return 1'b0;  3: return 1'b0;  4: return 1'b0;
      5: return 1'b1;  6: return 1'b1;  7: return 1'b0;  8: return 1'b1;
      9: return 1'b1; 10: return 1'b1; 11: return 1'b0; default: return 1'b0;
    endcase
  endfunction

  task automatic new_tx_inputs();
    for (int c = 0; c < CH; c++) tx_data[c*CB +: CB] = CB'($urandom);
    tx_a  = CH'($urandom);
    tx_b  = CH'($urandom);
    tx_en = CH'($urandom);
  endtask

  logic  exp_bits[FB];
  string exp_tag[FB];
  int    tk;
  int    gpos, gframe, mpos, mframe, syncs_left;
  logic  exp_ft, exp_fs, exp_sf;
  logic [CH-1:0] exp_sa, exp_sb;
  string sf_tag;

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; errs++;
      $display("FAIL R3 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; rx_bit = 1'b0; rx_sync = 1'b0;
    new_tx_inputs();
    repeat (3) @(negedge clk);
    chk("R1", "tx_bit", 32'(tx_bit), 32'd1);
    chk("R1", "tx_load", 32'(tx_load), 32'd1);
    chk("R1", "tx_frame", 32'(tx_frame), 32'd1);
    chk("R1", "rx strobes", {29'd0, rx_ft, rx_fs, rx_sf}, 32'd0);
    chk("R1", "rx_sig_a", 32'(rx_a), 32'd0);
    chk("R1", "rx_sig_b", 32'(rx_b), 32'd0);
    rst_ni = 1'b1;
    gpos = 0; gframe = 0; mpos = 0; mframe = 0; syncs_left = 2;
    exp_ft = 0; exp_fs = 0; exp_sf = 0; exp_sa = '0; exp_sb = '0; sf_tag = "R9";
    for (tk = 0; tk < RUN; tk++) begin
      // transmit side
      begin
        int pos, fnum;
        pos = tk % FB;
        fnum = (tk / FB) % 12 + 1;
        if (pos == 0) begin
          chk("R2", "tx S-bit", 32'(tx_bit), 32'(sref(fnum)));
          chk("R2", "tx_frame", 32'(tx_frame), 32'(fnum));
          chk("R3", "tx_load high", 32'(tx_load), 32'd1);
          for (int p = 1; p < FB; p++) begin
            int c, b;
            c = (p - 1) / CB;
            b = CB - 1 - (p - 1) % CB;
            exp_bits[p] = tx_data[c*CB + b];
            exp_tag[p] = "R3";
            if (b == 0) begin
              exp_tag[p] = "R6";
              if (tx_en[c] && fnum == 6)  begin exp_bits[p] = tx_a[c]; exp_tag[p] = "R4"; end
              if (tx_en[c] && fnum == 12) begin exp_bits[p] = tx_b[c]; exp_tag[p] = "R5"; end
            end
          end
        end else begin
          chk(exp_tag[pos], "tx payload bit", 32'(tx_bit), 32'(exp_bits[pos]));
          if (tx_load) chk("R3", "tx_load low", 32'(tx_load), 32'd0);
        end
        if (pos == 100) new_tx_inputs();
      end
      // receive side: judge previous bit, then drive next
      chk("R7", "rx_ft_err", 32'(rx_ft), 32'(exp_ft));
      chk("R8", "rx_fs_err", 32'(rx_fs), 32'(exp_fs));
      chk(sf_tag, "rx_sf_start", 32'(rx_sf), 32'(exp_sf));
      chk("R11", "rx_sig_a", 32'(rx_a), 32'(exp_sa));
      chk("R11", "rx_sig_b", 32'(rx_b), 32'(exp_sb));
      if (tk == JUMP_T) gpos = (gpos + 57) % FB;
      rx_sync = (tk > JUMP_T && syncs_left > 0 && gpos == 0 && gframe == 0);
      if (rx_sync) syncs_left--;
      if (gpos == 0) begin
        rx_bit = sref(gframe + 1);
        if (($urandom % 4) == 0) rx_bit = ~rx_bit;
        if (gframe == 0 && tk / SF == 1) rx_bit = ~sref(1);  // force Ft error with sf start
      end else begin
        rx_bit = 1'($urandom);
      end
      if (rx_sync) begin mpos = 0; mframe = 0; end
      sf_tag = rx_sync ? "R10" : "R9";
      exp_ft = (mpos == 0) && (mframe % 2 == 0) && (rx_bit != sref(mframe + 1));
      exp_fs = (mpos == 0) && (mframe % 2 == 1) && (rx_bit != sref(mframe + 1));
      exp_sf = (mpos == 0) && (mframe == 0);
      if (mpos > 0 && mpos % CB == 0) begin
        if (mframe == 5)  exp_sa[mpos / CB - 1] = rx_bit;
        if (mframe == 11) exp_sb[mpos / CB - 1] = rx_bit;
      end
      mpos++;
      if (mpos == FB) begin mpos = 0; mframe = (mframe + 1) % 12; end
      gpos++;
      if (gpos == FB) begin gpos = 0; gframe = (gframe + 1) % 12; end
      @(negedge clk);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule